// File: doc/BRIEF.md
# SPI Serial Port with Double-Buffered Receive

This block is a byte-wide SPI port for a larger chip. Software reaches it through a small register interface with three registers: control, status and a data buffer. It runs as a bus master, producing the serial clock from the system clock through a selectable divider. It can also run as a slave, following an external serial clock while an active-low select input is held low. Bits move through an internal 8-bit shift register, most significant bit first.

On the receive side the shift register and the data buffer form a double buffer. A finished byte is copied into the buffer, a buffer-full flag is raised and a one-cycle completion pulse is issued. A byte that finishes while the buffer still holds an unread byte is dropped and raises an overflow flag. The transmit side has only a single buffer: a write to the data register loads the buffer and the shift register together. In master mode that write also starts the transfer.

The idle level of the clock, the edge on which data changes, and the master's sampling point (middle or end of each bit) are all programmable.

Top module: `spi_port`

## Requirements
- R1: After reset, the control, status and data registers read 0x00, `ser_clk_o` is low and `irq_o` is low.
- R2: Register addresses are 0 = control, 1 = status, 2 = data, and 3 reads 0x00. All 8 control bits read back as written, except where R8, R9 or R10 change them. In status, bit 7 (sample-at-end) and bit 6 (change-on-trailing-edge) are read/write, bits 5..1 read 0, and bit 0 is the read-only buffer-full flag.
- R3: Control bits 1..0 pick the mode: 00 = master at system clock/4, 01 = master at /16, 10 = master at /64, 11 = slave. In master mode, a data write while idle sends 8 bits MSB first. The completion pulse appears 16·(divider/2) clock cycles after the write edge: 32 cycles for /4 and 128 cycles for /16.
- R4: The serial clock rests at the level of control bit 2. In master mode with status bit 6 = 1, each bit starts with the clock at its resting level and switches to the active level at mid-bit. With bit 6 = 0, each bit starts at the active level. After the last bit the clock returns to rest.
- R5: When a transfer completes with the buffer empty, the received byte is placed in the data register, status bit 0 goes to 1, and `irq_o` is high for exactly one cycle.
- R6: Reading the data register clears status bit 0.
- R7: In master mode with status bit 7 = 0, the input is sampled at the middle of each bit (the end of its first half). With bit 7 = 1, the input is sampled at the end of each bit.
- R8: A data write while a transfer is in progress is rejected: the shift register and the buffer are unchanged and control bit 4 (write collision) is set. Writing 0 to that bit clears it.
- R9: A transfer that completes while status bit 0 is still 1 leaves the data register unchanged and sets control bit 5 (overflow).
- R10: While control bit 3 (enable) is 0, the transfer logic is held idle, status bit 0 and control bits 4 and 5 are cleared, and data writes are ignored.
- R11: In slave mode, with `sel_n_i` low and status bit 6 = 1, the block samples `ser_in_i` on each idle-to-active clock edge and presents the loaded byte MSB first on `ser_out_o`. Status bit 7 has no effect in slave mode.
- R12: A data write that is accepted is immediately visible when the data register is read back.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_addr | input | 2 | Register select |
| reg_wr | input | 1 | Register write strobe |
| reg_wdata | input | 8 | Register write data |
| reg_rd | input | 1 | Register read strobe (clears buffer-full on data reads) |
| reg_rdata | output | 8 | Register read data, combinational from `reg_addr` |
| irq_o | output | 1 | One-cycle transfer-complete pulse |
| ser_clk_o | output | 1 | Serial clock driven in master mode |
| ser_clk_i | input | 1 | Serial clock received in slave mode |
| sel_n_i | input | 1 | Active-low slave select |
| ser_out_o | output | 1 | Serial data out |
| ser_in_i | input | 1 | Serial data in |

## Verification
In master mode the completion pulse is due exactly 16·(divider/2) cycles after the write edge. The bench counts falling edges from the write to the pulse, checks that the pulse has gone one edge later, and reads status and data only after it. The clock phase is checked one and two cycles after the write, at the falling edge, against the half-bit each cycle belongs to. Slave inputs go through a two-stage synchronizer, so slave results lag each external edge by about three cycles. The bench holds each external clock level for eight cycles and captures output data four cycles before its own sampling edge, which keeps every check clear of that lag.

// File: rtl/spi_port_pkg.sv
`timescale 1ns/1ps
package spi_port_pkg;
   localparam int unsigned BYTE_W = 8;

   typedef enum logic [1:0] {
      REG_CTRL = 2'd0,
      REG_STAT = 2'd1,
      REG_DATA = 2'd2,
      REG_NONE = 2'd3
   } reg_sel_e;

   // control register bit positions
   localparam int unsigned CTL_CPOL = 2;
   localparam int unsigned CTL_EN   = 3;
   localparam int unsigned CTL_WCOL = 4;
   localparam int unsigned CTL_OVF  = 5;
   localparam logic [1:0]  MODE_SLAVE = 2'b11;

   // status register bit positions
   localparam int unsigned ST_SMP = 7;
   localparam int unsigned ST_CKE = 6;
   localparam int unsigned ST_BF  = 0;
endpackage

// File: rtl/spi_port_sync.sv
`timescale 1ns/1ps
module spi_port_sync #(
   parameter int unsigned STAGES  = 2,
   parameter bit          RST_VAL = 1'b0
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d,
   output logic q
);
   if (STAGES < 2) begin : g_bad_stages
      $error("spi_port_sync: STAGES must be at least 2");
   end

   logic [STAGES-1:0] chain_q;

   for (genvar i = 0; i < STAGES; i++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) chain_q[i] <= RST_VAL;
         else if (i == 0) chain_q[i] <= d;
         else chain_q[i] <= chain_q[(i > 0) ? i - 1 : 0];
      end
   end

   assign q = chain_q[STAGES-1];
endmodule

// File: rtl/spi_port_clkgen.sv
`timescale 1ns/1ps
module spi_port_clkgen #(
   parameter int unsigned DIV_LO  = 4,
   parameter int unsigned DIV_MID = 16,
   parameter int unsigned DIV_HI  = 64
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       run,
   input  logic [1:0] rate,
   output logic       tick
);
   localparam int unsigned MAX_HALF = DIV_HI / 2;
   localparam int unsigned CW = (MAX_HALF > 2) ? $clog2(MAX_HALF) : 1;

   if ((DIV_LO < 2) || (DIV_LO % 2 != 0) || (DIV_MID % 2 != 0) || (DIV_HI % 2 != 0)) begin : g_bad_div
      $error("spi_port_clkgen: dividers must be even and at least 2");
   end
   if ((DIV_MID < DIV_LO) || (DIV_HI < DIV_MID)) begin : g_bad_order
      $error("spi_port_clkgen: dividers must be ordered LO <= MID <= HI");
   end

   logic [CW-1:0] cnt_q;
   logic [CW-1:0] lim;

   always_comb begin
      case (rate)
         2'd0:    lim = CW'(DIV_LO / 2 - 1);
         2'd1:    lim = CW'(DIV_MID / 2 - 1);
         default: lim = CW'(DIV_HI / 2 - 1);
      endcase
   end

   assign tick = run && (cnt_q == lim);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         cnt_q <= '0;
      else if (!run)      cnt_q <= '0;
      else if (tick)      cnt_q <= '0;
      else                cnt_q <= cnt_q + 1'b1;
   end
endmodule

// File: rtl/spi_port.sv
`timescale 1ns/1ps
module spi_port
   import spi_port_pkg::*;
#(
   parameter int unsigned DIV_LO      = 4,
   parameter int unsigned DIV_MID     = 16,
   parameter int unsigned DIV_HI      = 64,
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic [1:0]          reg_addr,
   input  logic                reg_wr,
   input  logic [BYTE_W-1:0]   reg_wdata,
   input  logic                reg_rd,
   output logic [BYTE_W-1:0]   reg_rdata,
   output logic                irq_o,
   output logic                ser_clk_o,
   input  logic                ser_clk_i,
   input  logic                sel_n_i,
   output logic                ser_out_o,
   input  logic                ser_in_i
);
   localparam int unsigned HW = $clog2(2 * BYTE_W);
   localparam int unsigned BW = $clog2(BYTE_W);
   localparam logic [HW-1:0] LAST_HALF = HW'(2 * BYTE_W - 1);
   localparam logic [BW-1:0] LAST_BIT  = BW'(BYTE_W - 1);

   if (BYTE_W != 8) begin : g_bad_width
      $error("spi_port: the shifter is defined for 8-bit bytes");
   end

   // registers
   logic [BYTE_W-1:0] ctrl_q, buf_q, sh_q;
   logic              smp_q, cke_q, bf_q, out_q, busy_q, irq_q, lvl_d;
   logic [HW-1:0]     half_q;
   logic [BW-1:0]     bits_q;

   // decoded control
   logic en, cpol, slave;
   assign en    = ctrl_q[CTL_EN];
   assign cpol  = ctrl_q[CTL_CPOL];
   assign slave = (ctrl_q[1:0] == MODE_SLAVE);

   // register strobes
   logic wr_ctrl, wr_stat, wr_data_hit, rd_clear;
   assign wr_ctrl     = reg_wr && (reg_addr == REG_CTRL);
   assign wr_stat     = reg_wr && (reg_addr == REG_STAT);
   assign wr_data_hit = reg_wr && (reg_addr == REG_DATA) && en;
   assign rd_clear    = reg_rd && (reg_addr == REG_DATA);

   // master clock divider
   logic tick;
   spi_port_clkgen #(.DIV_LO(DIV_LO), .DIV_MID(DIV_MID), .DIV_HI(DIV_HI)) u_clkgen (
      .clk (clk), .rst_n (rst_n),
      .run (busy_q && en && !slave),
      .rate(ctrl_q[1:0]),
      .tick(tick)
   );

   // slave clock and select synchronizers
   logic sclk_s, seln_s;
   spi_port_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_sync_clk (
      .clk(clk), .rst_n(rst_n), .d(ser_clk_i), .q(sclk_s));
   spi_port_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync_sel (
      .clk(clk), .rst_n(rst_n), .d(sel_n_i), .q(seln_s));

   logic lvl, lead, trail;
   assign lvl   = sclk_s ^ cpol;
   assign lead  = lvl && !lvl_d;
   assign trail = !lvl && lvl_d;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) lvl_d <= 1'b0;
      else        lvl_d <= lvl;
   end

   // shift events
   logic m_sample, m_shout, m_done, s_act, s_sample, s_shout, s_done;
   assign m_sample = tick && (smp_q ? half_q[0] : !half_q[0]);
   assign m_shout  = tick && half_q[0] && (half_q != LAST_HALF);
   assign m_done   = tick && (half_q == LAST_HALF);
   assign s_act    = slave && en && !seln_s;
   assign s_sample = s_act && (cke_q ? lead : trail);
   assign s_shout  = s_act && (cke_q ? trail : lead);
   assign s_done   = s_sample && (bits_q == LAST_BIT);

   logic sample, shout, done, busy, collide, load, ovf_set;
   logic [BYTE_W-1:0] sh_next, rx_byte;
   assign sample  = m_sample || s_sample;
   assign shout   = m_shout || s_shout;
   assign done    = m_done || s_done;
   assign busy    = slave ? (s_act && (bits_q != '0)) : busy_q;
   assign collide = wr_data_hit && busy;
   assign load    = wr_data_hit && !busy;
   assign ovf_set = done && bf_q && !rd_clear;
   assign sh_next = {sh_q[BYTE_W-2:0], ser_in_i};
   assign rx_byte = sample ? sh_next : sh_q;

   // control and status registers
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctrl_q <= '0;
         smp_q  <= 1'b0;
         cke_q  <= 1'b0;
      end else begin
         if (wr_ctrl) ctrl_q <= reg_wdata;
         if (!en) begin
            ctrl_q[CTL_WCOL] <= 1'b0;
            ctrl_q[CTL_OVF]  <= 1'b0;
         end else begin
            if (collide) ctrl_q[CTL_WCOL] <= 1'b1;
            if (ovf_set) ctrl_q[CTL_OVF]  <= 1'b1;
         end
         if (wr_stat) begin
            smp_q <= reg_wdata[ST_SMP];
            cke_q <= reg_wdata[ST_CKE];
         end
      end
   end

   // shifter, sequencing and receive buffer
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sh_q <= '0; buf_q <= '0; out_q <= 1'b0; busy_q <= 1'b0;
         half_q <= '0; bits_q <= '0; bf_q <= 1'b0; irq_q <= 1'b0;
      end else if (!en) begin
         sh_q <= '0; out_q <= 1'b0; busy_q <= 1'b0;
         half_q <= '0; bits_q <= '0; bf_q <= 1'b0; irq_q <= 1'b0;
      end else begin
         irq_q <= done;
         if (load) begin
            sh_q   <= reg_wdata;
            out_q  <= reg_wdata[BYTE_W-1];
            busy_q <= !slave;
            half_q <= '0;
         end else begin
            if (sample) sh_q  <= sh_next;
            if (shout)  out_q <= sample ? sh_q[BYTE_W-2] : sh_q[BYTE_W-1];
            if (m_done) busy_q <= 1'b0;
            if (tick)   half_q <= half_q + 1'b1;
         end
         if (!s_act)        bits_q <= '0;
         else if (s_sample) bits_q <= bits_q + 1'b1;
         if (done && !ovf_set) begin
            buf_q <= rx_byte;
            bf_q  <= 1'b1;
         end else if (rd_clear) begin
            bf_q  <= 1'b0;
         end
         if (load) buf_q <= reg_wdata;
      end
   end

   // read mux and pins
   always_comb begin
      case (reg_addr)
         REG_CTRL: reg_rdata = ctrl_q;
         REG_STAT: reg_rdata = {smp_q, cke_q, 5'b0, bf_q};
         REG_DATA: reg_rdata = buf_q;
         default:  reg_rdata = '0;
      endcase
   end

   assign ser_clk_o = cpol ^ (busy_q && en && !slave && (half_q[0] == cke_q));
   assign ser_out_o = out_q;
   assign irq_o     = irq_q;
endmodule

// File: rtl/spi_port_chk.sv
`timescale 1ns/1ps
module spi_port_chk (
   input logic       clk,
   input logic       rst_n,
   input logic       en,
   input logic       cpol,
   input logic       bf,
   input logic       irq,
   input logic       rd_clear,
   input logic       done,
   input logic       m_done,
   input logic       ovf_set,
   input logic       collide,
   input logic       wcol,
   input logic       ovf,
   input logic [7:0] buf_val,
   input logic       ser_clk
);
   AST_IRQ_WITH_BF: assert property (@(posedge clk) disable iff (!rst_n)
      irq |-> bf);                                                   // R5
   AST_READ_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_clear && en && !done) |=> !bf);                            // R6
   AST_COLLIDE_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
      collide |=> wcol);                                             // R8
   AST_OVF_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
      ovf_set |=> (ovf && $stable(buf_val)));                        // R9
   AST_DISABLE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      !en |=> (!bf && !wcol && !ovf && !irq));                       // R10
   AST_CLK_RESTS: assert property (@(posedge clk) disable iff (!rst_n)
      m_done |=> (ser_clk == cpol));                                 // R4
endmodule

bind spi_port spi_port_chk u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .en       (en),
   .cpol     (cpol),
   .bf       (bf_q),
   .irq      (irq_q),
   .rd_clear (rd_clear),
   .done     (done),
   .m_done   (m_done),
   .ovf_set  (ovf_set),
   .collide  (collide),
   .wcol     (ctrl_q[4]),
   .ovf      (ctrl_q[5]),
   .buf_val  (buf_q),
   .ser_clk  (ser_clk_o)
);

// File: tb/spi_port_bench.sv
`timescale 1ns/1ps
module spi_port_bench;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [1:0] reg_addr = 2'd0;
   logic       reg_wr = 1'b0;
   logic [7:0] reg_wdata = 8'h00;
   logic       reg_rd = 1'b0;
   logic [7:0] reg_rdata;
   logic       irq_o, ser_clk_o, ser_out_o, ser_in_i;
   logic       ser_clk_i = 1'b0;
   logic       sel_n_i = 1'b1;
   logic [1:0] in_mode = 2'd0;   // 0 loopback, 1 serial clock, 2 bench driven
   logic       mosi_b = 1'b0;

   int errs = 0;
   int checks = 0;
   int irq_seen = 0;
   logic [7:0] exp_q[$];

   assign ser_in_i = (in_mode == 2'd0) ? ser_out_o :
                     (in_mode == 2'd1) ? ser_clk_o : mosi_b;

   spi_port u_spi_port (
      .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr),
      .reg_wdata(reg_wdata), .reg_rd(reg_rd), .reg_rdata(reg_rdata),
      .irq_o(irq_o), .ser_clk_o(ser_clk_o), .ser_clk_i(ser_clk_i),
      .sel_n_i(sel_n_i), .ser_out_o(ser_out_o), .ser_in_i(ser_in_i)
   );

   always #4 clk = ~clk;

   always @(negedge clk) if (rst_n && irq_o) irq_seen++;

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errs++;
         $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [1:0] a, input logic [7:0] d);
      @(negedge clk);
      reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
      @(negedge clk);
      reg_wr = 1'b0;
   endtask

   task automatic rd(input logic [1:0] a, output logic [7:0] d);
      @(negedge clk);
      reg_addr = a; reg_rd = 1'b1;
      #1 d = reg_rdata;
      @(negedge clk);
      reg_rd = 1'b0;
   endtask

   // monitor side of the scoreboard: pop the expected byte and compare
   task automatic rd_rx(input string req);
      logic [7:0] v, e;
      rd(2'd2, v);
      e = (exp_q.size() > 0) ? exp_q.pop_front() : 8'hxx;
      chk(req, v, e);
   endtask

   task automatic wait_irq(output int n);
      n = 0;
      while (!irq_o && n < 2000) begin
         @(negedge clk);
         n++;
      end
   endtask

   // driver side: start a master transfer and push the expected byte
   task automatic m_xfer(input logic [7:0] tx, input logic [7:0] exp, input int cyc,
                         input string req, input bit do_read);
      int n;
      logic [7:0] s;
      wr(2'd2, tx);
      wait_irq(n);
      chk({req, " completion delay"}, n, cyc);
      @(negedge clk);
      chk("R5 pulse one cycle", irq_o, 0);
      rd(2'd1, s);
      chk("R5 buffer full set", s[0], 1);
      if (do_read) begin
         exp_q.push_back(exp);
         rd_rx({req, " received byte"});
         rd(2'd1, s);
         chk("R6 read clears full", s[0], 0);
      end
   endtask

   task automatic s_xfer(input logic [7:0] ld, input logic [7:0] mo, input string req);
      logic [7:0] cap;
      int base;
      wr(2'd2, ld);
      exp_q.push_back(mo);
      in_mode = 2'd2;
      sel_n_i = 1'b0;
      repeat (6) @(negedge clk);
      base = irq_seen;
      for (int b = 7; b >= 0; b--) begin
         mosi_b = mo[b];
         repeat (4) @(negedge clk);
         cap[b] = ser_out_o;
         ser_clk_i = 1'b1;
         repeat (8) @(negedge clk);
         ser_clk_i = 1'b0;
         repeat (4) @(negedge clk);
      end
      chk({req, " slave sent byte"}, cap, ld);
      chk({req, " slave completion count"}, irq_seen - base, 1);
      rd_rx({req, " slave received byte"});
      sel_n_i = 1'b1;
      repeat (4) @(negedge clk);
   endtask

   initial begin
      #(8 * 150000);
      errs++; checks++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("  Result: errors=%0d of %0d checks", errs, checks);
      $finish;
   end

   initial begin
      logic [7:0] v;
      int n, base;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1 reset state
      rd(2'd0, v); chk("R1 control reset", v, 8'h00);
      rd(2'd1, v); chk("R1 status reset", v, 8'h00);
      rd(2'd2, v); chk("R1 data reset", v, 8'h00);
      chk("R1 clock low", ser_clk_o, 0);
      chk("R1 irq low", irq_o, 0);

      // R2 register access
      wr(2'd0, 8'hC8); rd(2'd0, v); chk("R2 control readback", v, 8'hC8);
      wr(2'd1, 8'hFF); rd(2'd1, v); chk("R2 status writable bits", v, 8'hC0);
      rd(2'd3, v); chk("R2 unused address", v, 8'h00);
      wr(2'd0, 8'h08);
      wr(2'd1, 8'h40);

      // R3 R5 R6 master loopback at /4, then /16
      in_mode = 2'd0;
      m_xfer(8'hA5, 8'hA5, 32, "R3 div4", 1'b1);
      wr(2'd0, 8'h09);
      m_xfer(8'h3C, 8'h3C, 128, "R3 div16", 1'b1);
      wr(2'd0, 8'h08);

      // R4 clock phase per half bit
      wr(2'd2, 8'hF0);
      exp_q.push_back(8'hF0);
      @(negedge clk); chk("R4 trailing mode first half", ser_clk_o, 0);
      @(negedge clk); chk("R4 trailing mode second half", ser_clk_o, 1);
      wait_irq(n); @(negedge clk);
      rd_rx("R4 trailing mode byte");
      wr(2'd1, 8'h00);
      wr(2'd2, 8'h0F);
      exp_q.push_back(8'h0F);
      @(negedge clk); chk("R4 leading mode first half", ser_clk_o, 1);
      wait_irq(n); @(negedge clk);
      chk("R4 clock rests after transfer", ser_clk_o, 0);
      rd_rx("R4 leading mode byte");

      // R7 sample point: input follows the serial clock
      in_mode = 2'd1;
      wr(2'd1, 8'h40); m_xfer(8'h55, 8'h00, 32, "R7 mid trailing", 1'b1);
      wr(2'd1, 8'hC0); m_xfer(8'h55, 8'hFF, 32, "R7 end trailing", 1'b1);
      wr(2'd1, 8'h00); m_xfer(8'h55, 8'hFF, 32, "R7 mid leading", 1'b1);
      wr(2'd1, 8'h80); m_xfer(8'h55, 8'h00, 32, "R7 end leading", 1'b1);

      // R4 inverted polarity
      wr(2'd1, 8'h40);
      wr(2'd0, 8'h0C);
      chk("R4 idle high", ser_clk_o, 1);
      m_xfer(8'h55, 8'hFF, 32, "R4 inverted mid", 1'b1);
      chk("R4 idle high after", ser_clk_o, 1);
      wr(2'd0, 8'h08);

      // R9 overflow keeps the unread byte
      in_mode = 2'd0;
      m_xfer(8'h11, 8'h11, 32, "R9 first", 1'b0);
      in_mode = 2'd1;
      m_xfer(8'h22, 8'h00, 32, "R9 second", 1'b0);
      rd(2'd0, v); chk("R9 overflow flag", v, 8'h28);
      rd(2'd2, v); chk("R9 buffer kept", v, 8'h22);
      wr(2'd0, 8'h08); rd(2'd0, v); chk("R9 overflow cleared", v, 8'h08);

      // R8 R12 write collision
      in_mode = 2'd0;
      wr(2'd2, 8'h5A);
      rd(2'd2, v); chk("R12 write visible", v, 8'h5A);
      wr(2'd2, 8'h77);
      rd(2'd0, v); chk("R8 collision flag", v, 8'h18);
      wait_irq(n); @(negedge clk);
      exp_q.push_back(8'h5A);
      rd_rx("R8 rejected write");
      wr(2'd0, 8'h08); rd(2'd0, v); chk("R8 collision cleared", v, 8'h08);

      // R10 disable
      m_xfer(8'h44, 8'h44, 32, "R10 setup", 1'b0);
      wr(2'd0, 8'h00);
      rd(2'd1, v); chk("R10 full cleared", v, 8'h40);
      base = irq_seen;
      wr(2'd2, 8'h99);
      for (int i = 0; i < 40; i++) begin
         @(negedge clk);
         if (ser_clk_o !== 1'b0) chk("R10 clock quiet", ser_clk_o, 0);
      end
      chk("R10 no completion", irq_seen - base, 0);
      rd(2'd2, v); chk("R10 write ignored", v, 8'h44);
      wr(2'd0, 8'h08);

      // R11 slave mode, sample select ignored
      wr(2'd0, 8'h0B);
      wr(2'd1, 8'h40);
      s_xfer(8'h96, 8'h3C, "R11 smp0");
      wr(2'd1, 8'hC0);
      s_xfer(8'h69, 8'hC3, "R11 smp1");

      $display("  Result: errors=%0d of %0d checks", errs, checks);
      $finish;
   end
endmodule